// File: doc/BRIEF.md
# Four-Thread Three-Literal Clause Evaluator

This block holds one clause of a three-literal CNF formula inside a parallel local-search satisfiability engine. Four independent search threads share it. Each thread keeps its own value for every literal, and literal polarity is folded into the loaded values, so no negation flag is stored. On each cycle a variable number may be broadcast for one thread together with a trial index (0 to 2). Every literal whose stored variable number equals the broadcast one has its value inverted into a tentative slot. The block then reports the clause status before and after that trial flip.

Variable membership is tested without comparators. The broadcast number is split into 4-bit nibbles, each nibble addresses a 16-entry one-bit array per literal, and a literal matches only when all of its arrays answer 1. Each thread and literal owns four storage slots. One slot is current and the other three receive tentative values. A 2-bit position register per thread marks the current slot. A commit moves that pointer onto the chosen trial's slot, so the tentative value becomes current without any data being copied.

The new status goes to a clause selector. The score bit goes to an adder tree, either as the raw new status or as a break indication (satisfied before, unsatisfied after).

Top module: `cev_clause_eval`

## Requirements
- R1: While reset is low, and after it is released, `out_valid`, `out_cur_sat`, `out_new_sat`, `out_score`, `out_thr` and `out_trial` are 0. All thread positions are slot 0, all literal values are 0 and no literal matches any variable number.
- R2: A literal matches a broadcast 8-bit variable number only when both 4-bit halves address a 1 in that literal's two membership arrays. A number sharing only one half with the loaded number does not match.
- R3: A broadcast with trial k (0, 1 or 2) writes, for each literal, the current value XOR its match into slot (position + 1 + k) mod 4 of that thread. `out_new_sat` is the OR of those three tentative values. Trial index 3 produces no output and writes nothing.
- R4: `out_cur_sat` is the OR of the three literals' current-slot values for the broadcast thread.
- R5: When `mode_break` is 1 during the broadcast, `out_score` = `out_cur_sat` AND NOT `out_new_sat`. When it is 0, `out_score` = `out_new_sat`.
- R6: Outputs are registered. `out_valid` rises in the cycle after an accepted broadcast, and `out_thr` and `out_trial` carry that broadcast's thread and trial.
- R7: A commit with trial k (0 to 2) sets the thread's position to (position + 1 + k) mod 4 at the clock edge. A broadcast to the same thread in that same cycle still reads the old position. A commit with trial 3 is ignored.
- R8: A value load writes the given bit into the current slot of the given literal and thread. A broadcast to that thread in the same cycle reads the value held before the load.
- R9: A variable load for literal 0, 1 or 2 replaces that literal's membership, so the old number stops matching and the new one matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mode_break | input | 1 | 1 selects break scoring, 0 selects new-status scoring |
| var_ld_en | input | 1 | Load a variable number into one literal |
| var_ld_lit | input | 2 | Literal index for the variable load |
| var_ld_num | input | 8 | Variable number to load |
| val_ld_en | input | 1 | Load a literal value into the current slot |
| val_ld_lit | input | 2 | Literal index for the value load |
| val_ld_thr | input | 2 | Thread for the value load |
| val_ld_bit | input | 1 | Literal value (polarity already applied) |
| bc_valid | input | 1 | Broadcast strobe |
| bc_var | input | 8 | Broadcast variable number |
| bc_thr | input | 2 | Broadcast thread |
| bc_trial | input | 2 | Trial index, 0 to 2 accepted |
| cm_valid | input | 1 | Commit strobe |
| cm_thr | input | 2 | Thread to commit |
| cm_trial | input | 2 | Chosen trial, 0 to 2 accepted |
| out_valid | output | 1 | Result valid |
| out_thr | output | 2 | Thread of the result |
| out_trial | output | 2 | Trial of the result |
| out_cur_sat | output | 1 | Clause status before the trial flip |
| out_new_sat | output | 1 | Clause status after the trial flip, to the clause selector |
| out_score | output | 1 | Score contribution, to the adder tree |

## Verification
Two pairs of operations can hit the same thread in one cycle. A commit can coincide with a broadcast, and a value load can coincide with a broadcast. The bench drives each pair together on one thread. It checks that the result in the next cycle reflects the old position or the old literal value. It then checks that a following broadcast reflects the new state. The commit case is built so that the old and new current slots hold different clause values, so a design that applies the commit too early gives a visible status error.

// File: rtl/cev_pkg.sv
package cev_pkg;
  localparam int CEV_VAR_W  = 8;
  localparam int CEV_NIB_W  = 4;
  localparam int CEV_LIT_N  = 3;
  localparam int CEV_THR_N  = 4;
  localparam int CEV_SLOT_N = 4;
  localparam int CEV_LIT_W  = 2;
endpackage

// File: rtl/cev_rst_sync.sv
module cev_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/cev_member.sv
module cev_member #(
  parameter int VAR_W = cev_pkg::CEV_VAR_W,
  parameter int NIB_W = cev_pkg::CEV_NIB_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_en,
  input  logic [VAR_W-1:0] ld_var,
  input  logic [VAR_W-1:0] probe_var,
  output logic             hit
);
  localparam int NIB_N = VAR_W / NIB_W;
  localparam int DEPTH = 1 << NIB_W;

  logic [NIB_N-1:0] nib_hit;

  for (genvar n = 0; n < NIB_N; n++) begin : g_nib
    logic [DEPTH-1:0] arr_q;
    logic [DEPTH-1:0] arr_d;
    logic [NIB_W-1:0] ld_nib;
    logic [NIB_W-1:0] pr_nib;

    assign ld_nib = ld_var[n*NIB_W +: NIB_W];
    assign pr_nib = probe_var[n*NIB_W +: NIB_W];

    always_comb begin
      arr_d = '0;
      arr_d[ld_nib] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     arr_q <= '0;
      else if (ld_en) arr_q <= arr_d;
    end

    assign nib_hit[n] = arr_q[pr_nib];
  end

  assign hit = &nib_hit;
endmodule

// File: rtl/cev_lit_store.sv
module cev_lit_store #(
  parameter int THR_N  = cev_pkg::CEV_THR_N,
  parameter int SLOT_N = cev_pkg::CEV_SLOT_N
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [$clog2(THR_N)-1:0]  rd_thr,
  input  logic [$clog2(SLOT_N)-1:0] rd_slot,
  output logic                      rd_bit,
  input  logic                      wr_en,
  input  logic [$clog2(SLOT_N)-1:0] wr_slot,
  input  logic                      wr_bit,
  input  logic                      ld_en,
  input  logic [$clog2(THR_N)-1:0]  ld_thr,
  input  logic [$clog2(SLOT_N)-1:0] ld_slot,
  input  logic                      ld_bit
);
  localparam int THR_W  = $clog2(THR_N);
  localparam int SLOT_W = $clog2(SLOT_N);
  localparam int IDX_W  = THR_W + SLOT_W;
  localparam int BITS   = THR_N * SLOT_N;

  logic [BITS-1:0]  tbl_q;
  logic [BITS-1:0]  tbl_d;
  logic [IDX_W-1:0] rd_idx;
  logic [IDX_W-1:0] wr_idx;
  logic [IDX_W-1:0] ld_idx;

  assign rd_idx = {rd_thr, rd_slot};
  assign wr_idx = {rd_thr, wr_slot};
  assign ld_idx = {ld_thr, ld_slot};
  assign rd_bit = tbl_q[rd_idx];

  always_comb begin
    tbl_d = tbl_q;
    if (wr_en) tbl_d[wr_idx] = wr_bit;
    if (ld_en) tbl_d[ld_idx] = ld_bit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              tbl_q <= '0;
    else if (wr_en || ld_en) tbl_q <= tbl_d;
  end
endmodule

// File: rtl/cev_pos_ctrl.sv
module cev_pos_ctrl #(
  parameter int THR_N  = cev_pkg::CEV_THR_N,
  parameter int SLOT_N = cev_pkg::CEV_SLOT_N
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             cm_en,
  input  logic [$clog2(THR_N)-1:0]         cm_thr,
  input  logic [$clog2(SLOT_N)-1:0]        cm_trial,
  input  logic [$clog2(THR_N)-1:0]         bc_thr,
  input  logic [$clog2(SLOT_N)-1:0]        bc_trial,
  output logic [$clog2(SLOT_N)-1:0]        bc_pos,
  output logic [$clog2(SLOT_N)-1:0]        bc_slot,
  input  logic [$clog2(THR_N)-1:0]         ld_thr,
  output logic [$clog2(SLOT_N)-1:0]        ld_pos,
  output logic [THR_N*$clog2(SLOT_N)-1:0]  pos_flat
);
  localparam int SLOT_W = $clog2(SLOT_N);

  logic [SLOT_W-1:0] pos_q [THR_N];
  logic [SLOT_W-1:0] pos_d [THR_N];

  function automatic logic [SLOT_W-1:0] trial_slot(input logic [SLOT_W-1:0] pos,
                                                   input logic [SLOT_W-1:0] trial);
    return SLOT_W'(32'(pos) + 32'd1 + 32'(trial));
  endfunction

  always_comb begin
    for (int t = 0; t < THR_N; t++) pos_d[t] = pos_q[t];
    if (cm_en) pos_d[cm_thr] = trial_slot(pos_q[cm_thr], cm_trial);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int t = 0; t < THR_N; t++) pos_q[t] <= '0;
    end else if (cm_en) begin
      for (int t = 0; t < THR_N; t++) pos_q[t] <= pos_d[t];
    end
  end

  assign bc_pos  = pos_q[bc_thr];
  assign bc_slot = trial_slot(pos_q[bc_thr], bc_trial);
  assign ld_pos  = pos_q[ld_thr];

  for (genvar t = 0; t < THR_N; t++) begin : g_flat
    assign pos_flat[t*SLOT_W +: SLOT_W] = pos_q[t];
  end
endmodule

// File: rtl/cev_clause_eval.sv
module cev_clause_eval #(
  parameter int VAR_W  = cev_pkg::CEV_VAR_W,
  parameter int NIB_W  = cev_pkg::CEV_NIB_W,
  parameter int LIT_N  = cev_pkg::CEV_LIT_N,
  parameter int LIT_W  = cev_pkg::CEV_LIT_W,
  parameter int THR_N  = cev_pkg::CEV_THR_N,
  parameter int SLOT_N = cev_pkg::CEV_SLOT_N
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      mode_break,
  input  logic                      var_ld_en,
  input  logic [LIT_W-1:0]          var_ld_lit,
  input  logic [VAR_W-1:0]          var_ld_num,
  input  logic                      val_ld_en,
  input  logic [LIT_W-1:0]          val_ld_lit,
  input  logic [$clog2(THR_N)-1:0]  val_ld_thr,
  input  logic                      val_ld_bit,
  input  logic                      bc_valid,
  input  logic [VAR_W-1:0]          bc_var,
  input  logic [$clog2(THR_N)-1:0]  bc_thr,
  input  logic [$clog2(SLOT_N)-1:0] bc_trial,
  input  logic                      cm_valid,
  input  logic [$clog2(THR_N)-1:0]  cm_thr,
  input  logic [$clog2(SLOT_N)-1:0] cm_trial,
  output logic                      out_valid,
  output logic [$clog2(THR_N)-1:0]  out_thr,
  output logic [$clog2(SLOT_N)-1:0] out_trial,
  output logic                      out_cur_sat,
  output logic                      out_new_sat,
  output logic                      out_score
);
  localparam int THR_W   = $clog2(THR_N);
  localparam int SLOT_W  = $clog2(SLOT_N);
  localparam int TRIAL_N = SLOT_N - 1;

  logic                     rst_sync_n;
  logic                     bc_fire;
  logic                     cm_fire;
  logic [SLOT_W-1:0]        bc_pos;
  logic [SLOT_W-1:0]        bc_slot;
  logic [SLOT_W-1:0]        ld_pos;
  logic [THR_N*SLOT_W-1:0]  thr_pos;
  logic [LIT_N-1:0]         cur_vec;
  logic [LIT_N-1:0]         hit_vec;
  logic [LIT_N-1:0]         tent_vec;
  logic                     cur_sat_c;
  logic                     new_sat_c;
  logic                     score_c;

  logic                     valid_d;
  logic [THR_W-1:0]         thr_d;
  logic [SLOT_W-1:0]        trial_d;
  logic                     cur_d;
  logic                     new_d;
  logic                     score_d;

  cev_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  assign bc_fire = bc_valid && (32'(bc_trial) < TRIAL_N);
  assign cm_fire = cm_valid && (32'(cm_trial) < TRIAL_N);

  cev_pos_ctrl #(.THR_N(THR_N), .SLOT_N(SLOT_N)) u_pos (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .cm_en    (cm_fire),
    .cm_thr   (cm_thr),
    .cm_trial (cm_trial),
    .bc_thr   (bc_thr),
    .bc_trial (bc_trial),
    .bc_pos   (bc_pos),
    .bc_slot  (bc_slot),
    .ld_thr   (val_ld_thr),
    .ld_pos   (ld_pos),
    .pos_flat (thr_pos)
  );

  for (genvar g = 0; g < LIT_N; g++) begin : g_lit
    logic var_sel;
    logic val_sel;

    assign var_sel = var_ld_en && (32'(var_ld_lit) == g);
    assign val_sel = val_ld_en && (32'(val_ld_lit) == g);

    cev_member #(.VAR_W(VAR_W), .NIB_W(NIB_W)) u_member (
      .clk       (clk),
      .rst_n     (rst_sync_n),
      .ld_en     (var_sel),
      .ld_var    (var_ld_num),
      .probe_var (bc_var),
      .hit       (hit_vec[g])
    );

    assign tent_vec[g] = cur_vec[g] ^ hit_vec[g];

    cev_lit_store #(.THR_N(THR_N), .SLOT_N(SLOT_N)) u_store (
      .clk     (clk),
      .rst_n   (rst_sync_n),
      .rd_thr  (bc_thr),
      .rd_slot (bc_pos),
      .rd_bit  (cur_vec[g]),
      .wr_en   (bc_fire),
      .wr_slot (bc_slot),
      .wr_bit  (tent_vec[g]),
      .ld_en   (val_sel),
      .ld_thr  (val_ld_thr),
      .ld_slot (ld_pos),
      .ld_bit  (val_ld_bit)
    );
  end

  assign cur_sat_c = |cur_vec;
  assign new_sat_c = |tent_vec;
  assign score_c   = mode_break ? (cur_sat_c & ~new_sat_c) : new_sat_c;

  always_comb begin
    valid_d = bc_fire;
    thr_d   = bc_thr;
    trial_d = bc_trial;
    cur_d   = cur_sat_c;
    new_d   = new_sat_c;
    score_d = score_c;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) out_valid <= 1'b0;
    else             out_valid <= valid_d;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      out_thr     <= '0;
      out_trial   <= '0;
      out_cur_sat <= 1'b0;
      out_new_sat <= 1'b0;
      out_score   <= 1'b0;
    end else if (bc_fire) begin
      out_thr     <= thr_d;
      out_trial   <= trial_d;
      out_cur_sat <= cur_d;
      out_new_sat <= new_d;
      out_score   <= score_d;
    end
  end
endmodule

// File: rtl/cev_clause_eval_chk.sv
module cev_clause_eval_chk #(
  parameter int THR_W  = 2,
  parameter int SLOT_W = 2,
  parameter int THR_N  = 4
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    mode_break,
  input logic                    bc_valid,
  input logic [THR_W-1:0]        bc_thr,
  input logic [SLOT_W-1:0]       bc_trial,
  input logic                    cm_valid,
  input logic [SLOT_W-1:0]       cm_trial,
  input logic                    out_valid,
  input logic [THR_W-1:0]        out_thr,
  input logic [SLOT_W-1:0]       out_trial,
  input logic                    out_cur_sat,
  input logic                    out_new_sat,
  input logic                    out_score,
  input logic [THR_N*SLOT_W-1:0] thr_pos
);
  logic bc_ok;
  logic cm_ok;

  assign bc_ok = bc_valid && (bc_trial != '1);
  assign cm_ok = cm_valid && (cm_trial != '1);

  AST_VALID_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    bc_ok |=> out_valid); // R6

  AST_TAG_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    bc_ok |=> (out_thr == $past(bc_thr)) && (out_trial == $past(bc_trial))); // R6

  AST_NO_RESULT_T3: assert property (@(posedge clk) disable iff (!rst_n)
    !bc_ok |=> !out_valid); // R3

  AST_SCORE_BREAK: assert property (@(posedge clk) disable iff (!rst_n)
    (bc_ok && mode_break) |=> (out_score == (out_cur_sat && !out_new_sat))); // R5

  AST_SCORE_PLAIN: assert property (@(posedge clk) disable iff (!rst_n)
    (bc_ok && !mode_break) |=> (out_score == out_new_sat)); // R5

  AST_POS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cm_ok |=> $stable(thr_pos)); // R7

  AST_POS_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
    cm_ok |=> !$stable(thr_pos)); // R7
endmodule

bind cev_clause_eval cev_clause_eval_chk #(
  .THR_W  ($clog2(THR_N)),
  .SLOT_W ($clog2(SLOT_N)),
  .THR_N  (THR_N)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .mode_break  (mode_break),
  .bc_valid    (bc_valid),
  .bc_thr      (bc_thr),
  .bc_trial    (bc_trial),
  .cm_valid    (cm_valid),
  .cm_trial    (cm_trial),
  .out_valid   (out_valid),
  .out_thr     (out_thr),
  .out_trial   (out_trial),
  .out_cur_sat (out_cur_sat),
  .out_new_sat (out_new_sat),
  .out_score   (out_score),
  .thr_pos     (thr_pos)
);

// File: tb/cev_clause_eval_bench.sv
module cev_clause_eval_bench;
  logic       clk;
  logic       rst_n;
  logic       mode_break;
  logic       var_ld_en;
  logic [1:0] var_ld_lit;
  logic [7:0] var_ld_num;
  logic       val_ld_en;
  logic [1:0] val_ld_lit;
  logic [1:0] val_ld_thr;
  logic       val_ld_bit;
  logic       bc_valid;
  logic [7:0] bc_var;
  logic [1:0] bc_thr;
  logic [1:0] bc_trial;
  logic       cm_valid;
  logic [1:0] cm_thr;
  logic [1:0] cm_trial;
  logic       out_valid;
  logic [1:0] out_thr;
  logic [1:0] out_trial;
  logic       out_cur_sat;
  logic       out_new_sat;
  logic       out_score;

  int  n_chk;
  int  n_fail;
  bit  done;

  cev_clause_eval u_cev_clause_eval (
    .clk(clk), .rst_n(rst_n), .mode_break(mode_break),
    .var_ld_en(var_ld_en), .var_ld_lit(var_ld_lit), .var_ld_num(var_ld_num),
    .val_ld_en(val_ld_en), .val_ld_lit(val_ld_lit), .val_ld_thr(val_ld_thr),
    .val_ld_bit(val_ld_bit),
    .bc_valid(bc_valid), .bc_var(bc_var), .bc_thr(bc_thr), .bc_trial(bc_trial),
    .cm_valid(cm_valid), .cm_thr(cm_thr), .cm_trial(cm_trial),
    .out_valid(out_valid), .out_thr(out_thr), .out_trial(out_trial),
    .out_cur_sat(out_cur_sat), .out_new_sat(out_new_sat), .out_score(out_score)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // Vector: {var[17:10], thr[9:8], trial[7:6], mode[5], commit[4], exp_valid[3],
  //          exp_cur[2], exp_new[1], exp_score[0]}
  // Literal variables: L0=0x12, L1=0x34, L2=0x56.
  localparam int NV = 13;
  localparam logic [17:0] VEC [NV] = '{
    {8'h12, 2'd0, 2'd1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0},
    {8'h99, 2'd0, 2'd2, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0},
    {8'h56, 2'd0, 2'd0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1},
    {8'h34, 2'd1, 2'd0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0},
    {8'h14, 2'd1, 2'd1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0}, // R2 half match only
    {8'h12, 2'd2, 2'd3, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}, // R3 trial 3 rejected
    {8'h12, 2'd2, 2'd0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1},
    {8'h56, 2'd0, 2'd0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0},
    {8'h12, 2'd0, 2'd2, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0}, // R7 wrap 1+1+2 -> 0
    {8'h12, 2'd0, 2'd1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1},
    {8'h34, 2'd3, 2'd0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1},
    {8'h77, 2'd1, 2'd2, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
    {8'h12, 2'd3, 2'd1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1}
  };

  task automatic check_eq(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic idle_inputs();
    var_ld_en = 1'b0; val_ld_en = 1'b0; bc_valid = 1'b0; cm_valid = 1'b0;
  endtask

  task automatic load_var(input logic [1:0] lit, input logic [7:0] num);
    var_ld_en = 1'b1; var_ld_lit = lit; var_ld_num = num;
    @(negedge clk);
    var_ld_en = 1'b0;
  endtask

  task automatic load_val(input logic [1:0] lit, input logic [1:0] thr, input logic b);
    val_ld_en = 1'b1; val_ld_lit = lit; val_ld_thr = thr; val_ld_bit = b;
    @(negedge clk);
    val_ld_en = 1'b0;
  endtask

  task automatic set_bc(input logic [7:0] v, input logic [1:0] thr, input logic [1:0] tr);
    bc_valid = 1'b1; bc_var = v; bc_thr = thr; bc_trial = tr;
  endtask

  task automatic commit(input logic [1:0] thr, input logic [1:0] tr);
    cm_valid = 1'b1; cm_thr = thr; cm_trial = tr;
    @(negedge clk);
    cm_valid = 1'b0;
  endtask

  task automatic expect_res(input string tag, input logic c, input logic n, input logic s);
    check_eq({tag, " R6 valid"}, int'(out_valid), 1);
    check_eq({tag, " R4 cur"}, int'(out_cur_sat), int'(c));
    check_eq({tag, " R3 new"}, int'(out_new_sat), int'(n));
    check_eq({tag, " R5 score"}, int'(out_score), int'(s));
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    // R1: outputs held at zero during reset
    check_eq("R1 valid in reset", int'(out_valid), 0);
    check_eq("R1 cur in reset", int'(out_cur_sat), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    n_chk = 0; n_fail = 0; done = 1'b0;
    mode_break = 1'b1;
    var_ld_lit = '0; var_ld_num = '0; val_ld_lit = '0; val_ld_thr = '0; val_ld_bit = 1'b0;
    bc_var = '0; bc_thr = '0; bc_trial = '0; cm_thr = '0; cm_trial = '0;
    idle_inputs();
    do_reset();
    check_eq("R1 thr after reset", int'(out_thr), 0);
    check_eq("R1 trial after reset", int'(out_trial), 0);
    check_eq("R1 new after reset", int'(out_new_sat), 0);
    check_eq("R1 score after reset", int'(out_score), 0);

    // R9: initial variable loads
    load_var(2'd0, 8'h12);
    load_var(2'd1, 8'h34);
    load_var(2'd2, 8'h56);
    // R8: thread values (thr0: 0,0,1  thr1: 0,0,0  thr2: 1,0,0  thr3: 1,1,0)
    load_val(2'd2, 2'd0, 1'b1);
    load_val(2'd0, 2'd2, 1'b1);
    load_val(2'd0, 2'd3, 1'b1);
    load_val(2'd1, 2'd3, 1'b1);

    for (int i = 0; i < NV; i++) begin
      logic [17:0] v;
      v = VEC[i];
      mode_break = v[5];
      set_bc(v[17:10], v[9:8], v[7:6]);
      @(negedge clk);
      bc_valid = 1'b0;
      if (v[3]) begin
        expect_res($sformatf("vec%0d", i), v[2], v[1], v[0]);
        check_eq($sformatf("vec%0d R6 thr", i), int'(out_thr), int'(v[9:8]));
        check_eq($sformatf("vec%0d R6 trial", i), int'(out_trial), int'(v[7:6]));
      end else begin
        check_eq($sformatf("vec%0d R3 no result", i), int'(out_valid), 0);
      end
      if (v[4]) commit(v[9:8], v[7:6]);
    end

    // R7: commit and broadcast on thread 2 in the same cycle
    mode_break = 1'b1;
    set_bc(8'h34, 2'd2, 2'd1);
    cm_valid = 1'b1; cm_thr = 2'd2; cm_trial = 2'd0;
    @(negedge clk);
    bc_valid = 1'b0; cm_valid = 1'b0;
    expect_res("R7 same-cycle old pos", 1'b1, 1'b1, 1'b0);
    set_bc(8'h99, 2'd2, 2'd0);
    @(negedge clk);
    bc_valid = 1'b0;
    expect_res("R7 new pos used", 1'b0, 1'b0, 1'b0);

    // R8: value load coinciding with broadcast on thread 3
    load_val(2'd1, 2'd3, 1'b0);
    val_ld_en = 1'b1; val_ld_lit = 2'd0; val_ld_thr = 2'd3; val_ld_bit = 1'b0;
    set_bc(8'h99, 2'd3, 2'd0);
    @(negedge clk);
    val_ld_en = 1'b0; bc_valid = 1'b0;
    expect_res("R8 old value seen", 1'b1, 1'b1, 1'b0);
    set_bc(8'h99, 2'd3, 2'd0);
    @(negedge clk);
    bc_valid = 1'b0;
    expect_res("R8 new value seen", 1'b0, 1'b0, 1'b0);

    // R9: reload literal 1 with 0x9C, thread 1 all zero
    mode_break = 1'b0;
    load_var(2'd1, 8'h9C);
    set_bc(8'h34, 2'd1, 2'd0);
    @(negedge clk);
    bc_valid = 1'b0;
    expect_res("R9 old number dropped", 1'b0, 1'b0, 1'b0);
    set_bc(8'h9C, 2'd1, 2'd1);
    @(negedge clk);
    bc_valid = 1'b0;
    expect_res("R9 new number matches", 1'b0, 1'b1, 1'b1);

    // R7: commit to position 2, then wrap to position 1
    commit(2'd1, 2'd1);
    set_bc(8'h9C, 2'd1, 2'd2);
    @(negedge clk);
    bc_valid = 1'b0;
    expect_res("R7 pos2 current", 1'b1, 1'b0, 1'b0);
    commit(2'd1, 2'd2);
    set_bc(8'h55, 2'd1, 2'd0);
    @(negedge clk);
    bc_valid = 1'b0;
    expect_res("R7 wrap to pos1", 1'b0, 1'b0, 1'b0);

    // R1: reset mid-run clears membership and values
    do_reset();
    check_eq("R1 valid after second reset", int'(out_valid), 0);
    set_bc(8'h12, 2'd0, 2'd0);
    @(negedge clk);
    bc_valid = 1'b0;
    expect_res("R1 cleared tables", 1'b0, 1'b0, 1'b0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired before completion");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end
endmodule